// File: doc/BRIEF.md
# Debounced Button Menu Selector

This block sits between a board's raw push-buttons and slide switches and the logic that consumes a small menu selection. Every button passes through a two-flop synchronizer and a stability filter. The filtered levels drive a 2-bit function-selection code that the user steps forward with one button and backward with another, and the code wraps in both directions. A third button returns the code to zero and also produces a one-cycle reset pulse for downstream logic. A 2-bit parameter-selection code is taken from the low switch bits.

The filter length is set by parameters. In hardware mode it is derived from the clock frequency and a time in milliseconds. In simulation mode it is a short cycle count, so benches run quickly. Only rising edges of the filtered step buttons move the code, so holding a button gives a single step. Pressing both step buttons at once leaves the code where it is.

Top module: `btnsel_top`

## Requirements
- R1: While `rst_n` is low, `btn_clean_o`, `reset_pulse_o`, `fct_sel_o` and `par_sel_o` are all zero.
- R2: While the filtered reset button (index 3) is high, `fct_sel_o` is 0 on the following edge and stays 0, and steps requested in that time are discarded.
- R3: A raw button change reaches `btn_clean_o` exactly 2 + LIMIT clock edges after it is presented. A change that lasts fewer than LIMIT synchronized cycles never reaches the output.
- R4: A rising edge of filtered button 0, with filtered button 1 low, adds one to `fct_sel_o` modulo 4, so 3 goes to 0.
- R5: A rising edge of filtered button 1, with filtered button 0 low, subtracts one from `fct_sel_o` modulo 4, so 0 goes to 3.
- R6: A step button held for any length of time produces exactly one step.
- R7: When both step buttons are high at the filtered level, whether they rose together or one rose while the other was held, `fct_sel_o` does not change.
- R8: `par_sel_o` equals switch bits [1:0] as sampled at the previous clock edge, and the upper switch bits have no effect.
- R9: `reset_pulse_o` is high for exactly one cycle per rising edge of filtered button 3.
- R10: With `SIM_MODE` = 1 the filter LIMIT is `SIM_DEBOUNCE_CYC`. Otherwise it is `CLK_HZ`/1000 × `HW_DEBOUNCE_MS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Active-low asynchronous chip reset |
| btn_raw_i | input | N_BTN | Raw, asynchronous push-button levels |
| sw_raw_i | input | N_SW | Raw slide-switch levels |
| btn_clean_o | output | N_BTN | Synchronized, filtered button levels |
| reset_pulse_o | output | 1 | One-cycle pulse on a reset-button press |
| fct_sel_o | output | SEL_W | Function-selection code |
| par_sel_o | output | SEL_W | Parameter-selection code from switches |

## Verification
The bench measures the exact filter latency. A design with an off-by-one counter would release the clean level a cycle early or late, and a design without a filter would let a three-cycle glitch through. It walks the code eight steps up and eight steps down and compares each value with modular arithmetic. A design that saturates or wraps wrongly fails at the 3-to-0 and 0-to-3 crossings. It also holds buttons for long periods, presses both step buttons together, and holds one step button while pressing the other, to catch level-triggered stepping and a missing tie rule. Finally it sweeps all sixteen switch patterns to show that the upper switch bits are ignored.

// File: rtl/btnsel_pkg.sv
package btnsel_pkg;

   // Width of both selection codes
   localparam int unsigned SEL_W = 2;

   // Filter length in clock cycles for the chosen mode
   function automatic int unsigned filter_limit(input bit sim_mode,
                                                input int unsigned sim_cyc,
                                                input int unsigned clk_hz,
                                                input int unsigned ms);
      if (sim_mode) return sim_cyc;
      return (clk_hz / 1000) * ms;
   endfunction

   // Counter width able to hold 0 .. limit-1
   function automatic int unsigned cnt_width(input int unsigned limit);
      if (limit <= 2) return 1;
      return $clog2(limit);
   endfunction

endpackage

// File: rtl/btnsel_debounce.sv
module btnsel_debounce #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   import btnsel_pkg::*;

   localparam int unsigned CNT_W = cnt_width(LIMIT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("btnsel_debounce: LIMIT must be at least 1");
   end

   logic             meta_q, sync_q;
   logic [CNT_W-1:0] cnt_q;

   // Two-flop synchronizer for the asynchronous pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         meta_q <= raw_i;
         sync_q <= meta_q;
      end
   end

   // The output follows only after LIMIT cycles of disagreement
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clean_o <= 1'b0;
      end else if (sync_q == clean_o) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         clean_o <= sync_q;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R3: the output holds whenever the synchronized input agrees with it
   p_agree_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q == clean_o) |=> $stable(clean_o));

   // R3: a change of the output always follows the synchronized input
   p_change_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clean_o) |-> (clean_o == $past(sync_q)));

endmodule

// File: rtl/btnsel_edge.sv
module btnsel_edge #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_rise
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];

      // R6 / R9: a rise lasts a single cycle
      p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[g] |=> !rise_o[g]);
   end

endmodule

// File: rtl/btnsel_fsm.sv
module btnsel_fsm #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_lvl_i,
   input  logic             up_lvl_i,
   input  logic             dn_lvl_i,
   input  logic             up_rise_i,
   input  logic             dn_rise_i,
   output logic [SEL_W-1:0] sel_o
);
   typedef enum logic [1:0] {ACT_HOLD, ACT_CLR, ACT_UP, ACT_DN} act_e;

   act_e             act;
   logic [SEL_W-1:0] sel_nxt;

   // Reset wins. A step needs the opposite button to be released.
   always_comb begin
      if (clr_lvl_i)                   act = ACT_CLR;
      else if (up_rise_i && !dn_lvl_i) act = ACT_UP;
      else if (dn_rise_i && !up_lvl_i) act = ACT_DN;
      else                             act = ACT_HOLD;
   end

   always_comb begin
      unique case (act)
         ACT_CLR: sel_nxt = '0;
         ACT_UP:  sel_nxt = sel_o + SEL_W'(1);
         ACT_DN:  sel_nxt = sel_o - SEL_W'(1);
         default: sel_nxt = sel_o;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_o <= '0;
      else        sel_o <= sel_nxt;
   end

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_lvl_i |=> (sel_o == '0));

   p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl_i && up_rise_i && !dn_lvl_i) |=> (sel_o == SEL_W'($past(sel_o) + 1)));

   p_step_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl_i && dn_rise_i && !up_lvl_i) |=> (sel_o == SEL_W'($past(sel_o) - 1)));

   p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl_i && up_lvl_i && dn_lvl_i) |=> $stable(sel_o));

   p_no_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_lvl_i && !up_rise_i && !dn_rise_i) |=> $stable(sel_o));

endmodule

// File: rtl/btnsel_top.sv
module btnsel_top #(
   parameter int unsigned N_BTN            = 4,
   parameter int unsigned N_SW             = 4,
   parameter bit          SIM_MODE         = 1'b1,
   parameter int unsigned SIM_DEBOUNCE_CYC = 4,
   parameter int unsigned CLK_HZ           = 50_000_000,
   parameter int unsigned HW_DEBOUNCE_MS   = 10,
   parameter int unsigned IDX_UP           = 0,
   parameter int unsigned IDX_DN           = 1,
   parameter int unsigned IDX_CLR          = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_BTN-1:0]              btn_raw_i,
   input  logic [N_SW-1:0]               sw_raw_i,
   output logic [N_BTN-1:0]              btn_clean_o,
   output logic                          reset_pulse_o,
   output logic [btnsel_pkg::SEL_W-1:0]  fct_sel_o,
   output logic [btnsel_pkg::SEL_W-1:0]  par_sel_o
);
   import btnsel_pkg::*;

   localparam int unsigned LIMIT = filter_limit(SIM_MODE, SIM_DEBOUNCE_CYC,
                                                CLK_HZ, HW_DEBOUNCE_MS);

   // Elaboration checks on the configuration
   if (N_SW < SEL_W) begin : g_bad_sw
      $error("btnsel_top: N_SW must cover the selection width");
   end
   if (IDX_UP >= N_BTN || IDX_DN >= N_BTN || IDX_CLR >= N_BTN) begin : g_bad_idx
      $error("btnsel_top: button index out of range");
   end
   if (IDX_UP == IDX_DN || IDX_UP == IDX_CLR || IDX_DN == IDX_CLR) begin : g_dup_idx
      $error("btnsel_top: button roles must be distinct");
   end
   if (LIMIT < 1) begin : g_bad_lim
      $error("btnsel_top: filter limit must be at least 1");
   end

   logic [N_BTN-1:0] rise;

   // One filter per button
   for (genvar g = 0; g < N_BTN; g++) begin : g_filt
      btnsel_debounce #(.LIMIT(LIMIT)) i_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (btn_raw_i[g]),
         .clean_o (btn_clean_o[g])
      );
   end

   btnsel_edge #(.WIDTH(N_BTN)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (btn_clean_o),
      .rise_o (rise)
   );

   btnsel_fsm #(.SEL_W(SEL_W)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_lvl_i (btn_clean_o[IDX_CLR]),
      .up_lvl_i  (btn_clean_o[IDX_UP]),
      .dn_lvl_i  (btn_clean_o[IDX_DN]),
      .up_rise_i (rise[IDX_UP]),
      .dn_rise_i (rise[IDX_DN]),
      .sel_o     (fct_sel_o)
   );

   assign reset_pulse_o = rise[IDX_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_sel_o <= '0;
      else        par_sel_o <= sw_raw_i[SEL_W-1:0];
   end

   p_par_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (par_sel_o == $past(sw_raw_i[SEL_W-1:0])));

   p_pulse_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse_o |-> btn_clean_o[IDX_CLR]);

   always_comb begin
      if (!rst_n) begin
         a_reset_zero_r1: assert (fct_sel_o == '0 && par_sel_o == '0);
      end
   end

endmodule

// File: tb/test_btnsel_top.sv
module test_btnsel_top;
   localparam int unsigned LIM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] btn = '0;
   logic [3:0] sw = '0;
   logic [3:0] clean;
   logic       rpulse;
   logic [1:0] fct, par;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   btnsel_top #(.SIM_MODE(1'b1), .SIM_DEBOUNCE_CYC(LIM)) i_btnsel_top (
      .clk           (clk),
      .rst_n         (rst_n),
      .btn_raw_i     (btn),
      .sw_raw_i      (sw),
      .btn_clean_o   (clean),
      .reset_pulse_o (rpulse),
      .fct_sel_o     (fct),
      .par_sel_o     (par)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Press pattern, hold, release, settle
   task automatic press(input logic [3:0] pat, input int hold);
      @(negedge clk);
      btn = pat;
      idle(hold);
      btn = '0;
      idle(3 * LIM);
   endtask

   initial begin
      int exp_sel;
      int pulses;
      // R1: reset state
      sw = 4'hF;
      idle(3);
      check("R1 fct", fct, 0);
      check("R1 par", par, 0);
      check("R1 clean", clean, 0);
      check("R1 pulse", rpulse, 0);
      @(negedge clk);
      rst_n = 1'b1;
      sw = '0;
      idle(4);

      // R3 and R10: exact latency = 2 + LIM edges
      @(negedge clk);
      btn[2] = 1'b1;
      repeat (1 + LIM) @(posedge clk);
      @(negedge clk);
      check("R3 before latency", clean[2], 0);
      @(posedge clk);
      @(negedge clk);
      check("R3 at latency", clean[2], 1);
      btn[2] = 1'b0;
      idle(3 * LIM);
      check("R3 release", clean[2], 0);

      // R3: a glitch one cycle short of LIM is rejected
      @(negedge clk);
      btn[2] = 1'b1;
      idle(LIM - 1);
      btn[2] = 1'b0;
      for (int i = 0; i < 3 * LIM; i++) begin
         @(negedge clk);
         check("R3 glitch rejected", clean[2], 0);
      end

      // R9 and R2: reset button pulse width and clearing
      press(4'b0001, 2 * LIM);
      check("R4 pre-reset step", fct, 1);
      pulses = 0;
      @(negedge clk);
      btn = 4'b1000;
      for (int i = 0; i < 6 * LIM; i++) begin
         @(negedge clk);
         if (rpulse) pulses++;
      end
      check("R2 cleared while held", fct, 0);
      // R2: step requested while reset held is discarded
      btn = 4'b1001;
      idle(4 * LIM);
      check("R2 step ignored under reset", fct, 0);
      btn = '0;
      for (int i = 0; i < 3 * LIM; i++) begin
         @(negedge clk);
         if (rpulse) pulses++;
      end
      check("R9 single pulse", pulses, 1);
      check("R2 after release", fct, 0);

      // R4: eight up steps, wraps twice
      exp_sel = 0;
      for (int k = 0; k < 8; k++) begin
         press(4'b0001, 2 * LIM);
         exp_sel = (exp_sel + 1) % 4;
         check("R4 up step", fct, exp_sel);
      end

      // R5: eight down steps
      for (int k = 0; k < 8; k++) begin
         press(4'b0010, 2 * LIM);
         exp_sel = (exp_sel + 3) % 4;
         check("R5 down step", fct, exp_sel);
      end

      // R6: long holds give one step each
      press(4'b0001, 40 * LIM);
      exp_sel = (exp_sel + 1) % 4;
      check("R6 long up", fct, exp_sel);
      press(4'b0010, 40 * LIM);
      exp_sel = (exp_sel + 3) % 4;
      check("R6 long down", fct, exp_sel);

      // R7: both together
      for (int k = 0; k < 4; k++) begin
         press(4'b0011, 2 * LIM);
         check("R7 both together", fct, exp_sel);
      end
      // R7: down held, then up pressed
      @(negedge clk);
      btn = 4'b0010;
      idle(3 * LIM);
      exp_sel = (exp_sel + 3) % 4;
      check("R7 first down counted", fct, exp_sel);
      btn = 4'b0011;
      idle(3 * LIM);
      check("R7 up while down held", fct, exp_sel);
      btn = '0;
      idle(3 * LIM);
      check("R7 after release", fct, exp_sel);

      // R8: sweep all switch values
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         sw = 4'(v);
         @(negedge clk);
         check("R8 par from switches", par, v % 4);
         check("R8 fct untouched", fct, exp_sel);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule